// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank with Interrupt Register Forwarding

This block is the software-facing register bank of a general-purpose I/O controller. It sits on an APB bus and holds, for each of up to four ports of up to 32 lines, an output-value register and a direction register. These two registers drive the output values and output enables of the pins. A read-only pin-level register per port returns the pin inputs after a two-flop synchroniser.

Interrupt control for the first port lives in a separate interrupt unit. This block only decodes the interrupt-control offsets. It forwards each access over a small register bus as a strobe, a register code and write data, and returns that unit's read data on the APB bus. A static parameter chooses between two address layouts for the interrupt registers. The number of ports and the line count of each port are also static parameters.

Top module: `gpio_apb_regbank`

## Requirements
- R1: While reset is asserted at a clock edge, every value and direction register returns to zero, so `gpio_out` and `gpio_oe` are all zero after that edge.
- R2: Port p (p = 0..3) has its value register at byte offset 12*p and its direction register at 12*p+4. A write changes only the addressed register. The value register drives `gpio_out[32p+31:32p]` and the direction register drives `gpio_oe[32p+31:32p]`, where 1 means output. Both read back as written.
- R3: Port p's pin-level register at byte offset 0x50+4*p returns `pin_in[32p+31:32p]` through two register stages. A level applied before one clock edge is not yet visible. After a second edge it is.
- R4: Lines at or above a port's configured line count read as zero in all three of its registers, ignore writes and never drive `gpio_out` or `gpio_oe`.
- R5: For a port index at or above `NUM_PORTS`, the value, direction and pin-level offsets read as zero, and writes to them change no output.
- R6: In the base layout, the interrupt offsets map to these codes: 0x30 enable (code 0), 0x34 mask (1), 0x38 type (2), 0x3c polarity (3), 0x40 status (4), 0x48 debounce (5) and 0x4c end-of-interrupt (6). During the access phase of a write, `irq_wr` is high with `irq_sel` set to the code and `irq_wdata` equal to `pwdata`.
- R7: In the alternate layout the map is: 0x30 enable, 0x34 type, 0x38 polarity, 0x3c status, 0x40 end-of-interrupt, 0x44 mask and 0x48 debounce. 0x4c is unmapped.
- R8: The end-of-interrupt register is write-only. Reads of it return zero and never raise `irq_rd`.
- R9: The status register is read-only. Writes to it never raise `irq_wr`.
- R10: Every transfer completes with no wait state (`pready` high). Reads of unmapped offsets, including any with address bits above bit 7 set, return zero and raise no strobe.
- R11: A read of a readable interrupt offset raises `irq_rd` with `irq_sel` set to the code during the access phase, and `prdata` equals `irq_rdata` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pin_in | input | 32*NUM_PORTS | Pin input levels, 32 per port |
| gpio_out | output | 32*NUM_PORTS | Pin output values |
| gpio_oe | output | 32*NUM_PORTS | Pin output enables |
| irq_wr | output | 1 | Write strobe to the interrupt unit |
| irq_rd | output | 1 | Read strobe to the interrupt unit |
| irq_sel | output | 3 | Interrupt register code |
| irq_wdata | output | 32 | Write data to the interrupt unit |
| irq_rdata | input | 32 | Read data from the interrupt unit |

## Verification
A corrupted value or direction register shows on `gpio_out` or `gpio_oe` at the clock edge right after the write that caused it. It persists until the next write to the same register. A wrong decode shows in the same access-phase cycle, as a strobe with the wrong code, a missing strobe or a non-zero read of an unmapped offset. A synchroniser that is one stage too short or too long shows as a pin level that is visible one edge early or one edge late. The bench runs the base and alternate layouts side by side on the same bus stimulus. It probes the read-back at exactly one edge and two edges after a pin change.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    localparam int unsigned MAX_PORTS   = 4;
    localparam int unsigned LINE_W      = 32;
    localparam int unsigned OFS_W       = 8;
    localparam int unsigned PORT_STRIDE = 12;

    typedef enum logic [2:0] {
        IRQ_ENABLE   = 3'd0,
        IRQ_MASK     = 3'd1,
        IRQ_TYPE     = 3'd2,
        IRQ_POLARITY = 3'd3,
        IRQ_STATUS   = 3'd4,
        IRQ_DEBOUNCE = 3'd5,
        IRQ_EOI      = 3'd6
    } irq_reg_e;

    typedef enum logic {
        LAYOUT_BASE = 1'b0,
        LAYOUT_ALT  = 1'b1
    } irq_layout_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] port;
        logic       is_dir;
    } port_hit_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] port;
    } pin_hit_t;

    typedef struct packed {
        logic     hit;
        irq_reg_e id;
    } irq_hit_t;

    function automatic logic [LINE_W-1:0] line_mask(int unsigned lines);
        logic [LINE_W-1:0] m = '0;
        for (int i = 0; i < LINE_W; i++)
            if (i < int'(lines)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic port_hit_t decode_port(logic [OFS_W-1:0] ofs);
        port_hit_t r = '0;
        for (int p = 0; p < MAX_PORTS; p++) begin
            if (ofs == OFS_W'(p * PORT_STRIDE)) begin
                r.hit = 1'b1; r.port = 2'(p); r.is_dir = 1'b0;
            end
            if (ofs == OFS_W'(p * PORT_STRIDE + 4)) begin
                r.hit = 1'b1; r.port = 2'(p); r.is_dir = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic pin_hit_t decode_pin(logic [OFS_W-1:0] ofs);
        pin_hit_t r;
        r.hit  = (ofs[7:4] == 4'h5);
        r.port = ofs[3:2];
        return r;
    endfunction

    function automatic irq_hit_t decode_irq(logic [OFS_W-1:0] ofs, irq_layout_e lay);
        irq_hit_t r;
        r.hit = 1'b1;
        r.id  = IRQ_ENABLE;
        if (lay == LAYOUT_BASE) begin
            case (ofs)
                8'h30: r.id = IRQ_ENABLE;
                8'h34: r.id = IRQ_MASK;
                8'h38: r.id = IRQ_TYPE;
                8'h3c: r.id = IRQ_POLARITY;
                8'h40: r.id = IRQ_STATUS;
                8'h48: r.id = IRQ_DEBOUNCE;
                8'h4c: r.id = IRQ_EOI;
                default: r.hit = 1'b0;
            endcase
        end else begin
            case (ofs)
                8'h30: r.id = IRQ_ENABLE;
                8'h34: r.id = IRQ_TYPE;
                8'h38: r.id = IRQ_POLARITY;
                8'h3c: r.id = IRQ_STATUS;
                8'h40: r.id = IRQ_EOI;
                8'h44: r.id = IRQ_MASK;
                8'h48: r.id = IRQ_DEBOUNCE;
                default: r.hit = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // Assertion support: count edges since reset, saturating at two.
    logic [1:0] edges_seen;
    always_ff @(posedge clk) begin
        if (rst)                 edges_seen <= 2'd0;
        else if (edges_seen != 2'd2) edges_seen <= edges_seen + 2'd1;
    end

    a_r3_two_stage_latency: assert property (@(posedge clk) disable iff (rst)
        (edges_seen == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_value,
    input  logic              wr_dir,
    input  logic [LINE_W-1:0] wdata,
    output logic [LINE_W-1:0] value_q,
    output logic [LINE_W-1:0] dir_q
);
    localparam logic [LINE_W-1:0] LIVE = line_mask(LINES);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            dir_q   <= '0;
        end else begin
            if (wr_value) value_q <= wdata & LIVE;
            if (wr_dir)   dir_q   <= wdata & LIVE;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (value_q == '0 && dir_q == '0));
    a_r2_value_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_value |=> $stable(value_q));
    a_r2_dir_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir_q));
    a_r4_dead_lines_quiet: assert property (@(posedge clk) disable iff (rst)
        ((value_q | dir_q) & ~LIVE) == '0);
endmodule

// File: rtl/gpio_irq_fwd.sv
module gpio_irq_fwd
    import gpio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              access,
    input  logic              write,
    input  irq_hit_t          hit,
    input  logic [LINE_W-1:0] wdata,
    output logic              irq_wr,
    output logic              irq_rd,
    output logic [2:0]        irq_sel,
    output logic [LINE_W-1:0] irq_wdata
);
    always_comb begin
        irq_wr    = 1'b0;
        irq_rd    = 1'b0;
        irq_sel   = 3'd0;
        irq_wdata = wdata;
        if (hit.hit) begin
            irq_sel = hit.id;
            irq_wr  = access &&  write && (hit.id != IRQ_STATUS);
            irq_rd  = access && !write && (hit.id != IRQ_EOI);
        end
    end

    a_r8_eoi_never_read: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == IRQ_EOI) |-> !irq_rd);
    a_r9_status_never_written: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == IRQ_STATUS) |-> !irq_wr);
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_wr, irq_rd}));
    a_r11_strobe_needs_access: assert property (@(posedge clk) disable iff (rst)
        !access |-> !(irq_wr || irq_rd));
endmodule

// File: rtl/gpio_apb_regbank.sv
module gpio_apb_regbank
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NUM_PORTS            = 3,
    parameter int unsigned PORT_LINES [MAX_PORTS] = '{32, 20, 8, 32},
    parameter int unsigned ADDR_W               = 12,
    parameter irq_layout_e LAYOUT               = LAYOUT_BASE
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [LINE_W-1:0]             pwdata,
    output logic [LINE_W-1:0]             prdata,
    output logic                          pready,
    input  logic [NUM_PORTS*LINE_W-1:0]   pin_in,
    output logic [NUM_PORTS*LINE_W-1:0]   gpio_out,
    output logic [NUM_PORTS*LINE_W-1:0]   gpio_oe,
    output logic                          irq_wr,
    output logic                          irq_rd,
    output logic [2:0]                    irq_sel,
    output logic [LINE_W-1:0]             irq_wdata,
    input  logic [LINE_W-1:0]             irq_rdata
);
    localparam int unsigned HI_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] ofs;
    logic             in_window;
    logic             access;
    logic             wr_access;
    logic             rd_phase;
    port_hit_t        port_hit;
    pin_hit_t         pin_hit;
    irq_hit_t         irq_hit;
    irq_hit_t         irq_hit_gated;

    assign ofs       = paddr[OFS_W-1:0] & 8'hFC;
    assign in_window = (paddr[ADDR_W-1:OFS_W] == HI_W'(0));
    assign access    = psel && penable;
    assign wr_access = access && pwrite;
    assign rd_phase  = psel && !pwrite;
    assign pready    = 1'b1;

    always_comb begin
        port_hit = decode_port(ofs);
        pin_hit  = decode_pin(ofs);
        irq_hit  = decode_irq(ofs, LAYOUT);
        port_hit.hit = port_hit.hit && in_window;
        pin_hit.hit  = pin_hit.hit && in_window;
        irq_hit.hit  = irq_hit.hit && in_window;
    end

    logic [LINE_W-1:0] value_q [MAX_PORTS];
    logic [LINE_W-1:0] dir_q   [MAX_PORTS];
    logic [LINE_W-1:0] level_q [MAX_PORTS];

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_slot
        if (p < NUM_PORTS) begin : g_port
            localparam logic [LINE_W-1:0] LIVE = line_mask(PORT_LINES[p]);
            logic sel_p;
            logic [LINE_W-1:0] raw_level;
            assign sel_p = wr_access && port_hit.hit && (port_hit.port == 2'(p));

            gpio_port_regs #(.LINES(PORT_LINES[p])) u_regs (
                .clk      (clk),
                .rst      (rst),
                .wr_value (sel_p && !port_hit.is_dir),
                .wr_dir   (sel_p &&  port_hit.is_dir),
                .wdata    (pwdata),
                .value_q  (value_q[p]),
                .dir_q    (dir_q[p])
            );

            gpio_pin_sync #(.W(LINE_W)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (pin_in[p*LINE_W +: LINE_W]),
                .q   (raw_level)
            );

            assign level_q[p] = raw_level & LIVE;
            assign gpio_out[p*LINE_W +: LINE_W] = value_q[p];
            assign gpio_oe[p*LINE_W +: LINE_W]  = dir_q[p];
        end else begin : g_absent
            assign value_q[p] = '0;
            assign dir_q[p]   = '0;
            assign level_q[p] = '0;
        end
    end

    assign irq_hit_gated = irq_hit;

    gpio_irq_fwd u_irq (
        .clk       (clk),
        .rst       (rst),
        .access    (access),
        .write     (pwrite),
        .hit       (irq_hit_gated),
        .wdata     (pwdata),
        .irq_wr    (irq_wr),
        .irq_rd    (irq_rd),
        .irq_sel   (irq_sel),
        .irq_wdata (irq_wdata)
    );

    always_comb begin
        prdata = '0;
        if (rd_phase) begin
            if (port_hit.hit)
                prdata = port_hit.is_dir ? dir_q[port_hit.port] : value_q[port_hit.port];
            else if (pin_hit.hit)
                prdata = level_q[pin_hit.port];
            else if (irq_hit.hit && irq_hit.id != IRQ_EOI)
                prdata = irq_rdata;
        end
    end

    a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_phase && !port_hit.hit && !pin_hit.hit && !irq_hit.hit) |-> (prdata == '0));
    a_r8_eoi_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_phase && irq_hit.hit && irq_hit.id == IRQ_EOI) |-> (prdata == '0));
    a_r11_irq_read_passthrough: assert property (@(posedge clk) disable iff (rst)
        irq_rd |-> (prdata == irq_rdata));
    a_r10_no_strobe_outside: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> !(irq_wr || irq_rd));
endmodule

// File: tb/gpio_apb_regbank_test.sv
module gpio_apb_regbank_test;
    import gpio_regs_pkg::*;

    localparam int NP = 3;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst;
    logic psel, penable, pwrite;
    logic [AW-1:0] paddr;
    logic [31:0] pwdata;
    logic [NP*32-1:0] pin_in;

    logic [31:0] prdata, prdata_alt, irq_wdata, irq_wdata_alt, irq_rdata, irq_rdata_alt;
    logic pready, pready_alt, irq_wr, irq_rd, irq_wr_alt, irq_rd_alt;
    logic [2:0] irq_sel, irq_sel_alt;
    logic [NP*32-1:0] gpio_out, gpio_oe, gpio_out_alt, gpio_oe_alt;

    assign irq_rdata     = 32'hC0DE_0000 | {29'd0, irq_sel};
    assign irq_rdata_alt = 32'hC0DE_0000 | {29'd0, irq_sel_alt};

    always #5 clk = ~clk;

    gpio_apb_regbank #(.NUM_PORTS(NP), .ADDR_W(AW), .LAYOUT(LAYOUT_BASE)) uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pin_in(pin_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .irq_wr(irq_wr), .irq_rd(irq_rd), .irq_sel(irq_sel),
        .irq_wdata(irq_wdata), .irq_rdata(irq_rdata));

    gpio_apb_regbank #(.NUM_PORTS(NP), .ADDR_W(AW), .LAYOUT(LAYOUT_ALT)) uut_alt (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_alt), .pready(pready_alt),
        .pin_in(pin_in), .gpio_out(gpio_out_alt), .gpio_oe(gpio_oe_alt),
        .irq_wr(irq_wr_alt), .irq_rd(irq_rd_alt), .irq_sel(irq_sel_alt),
        .irq_wdata(irq_wdata_alt), .irq_rdata(irq_rdata_alt));

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Values captured in the access phase of the latest transfer.
    logic [31:0] c_rd, c_rd_alt, c_wdata;
    logic c_wr, c_rdstb, c_wr_alt, c_rdstb_alt, c_ready;
    logic [2:0] c_sel, c_sel_alt;

    task automatic check(input string req, input string what, input logic [95:0] got, input logic [95:0] exp);
        applied++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic capture();
        #1;
        c_rd = prdata; c_rd_alt = prdata_alt;
        c_wr = irq_wr; c_rdstb = irq_rd; c_sel = irq_sel; c_wdata = irq_wdata;
        c_wr_alt = irq_wr_alt; c_rdstb_alt = irq_rd_alt; c_sel_alt = irq_sel_alt;
        c_ready = pready && pready_alt;
    endtask

    task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        capture();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic apb_read(input logic [AW-1:0] a);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        capture();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "gpio_out after reset", gpio_out, '0);
        check("R1", "gpio_oe after reset", gpio_oe, '0);
        apb_read(12'h000); check("R1", "port A value", c_rd, 32'h0);
        apb_read(12'h010); check("R1", "port B dir", c_rd, 32'h0);
    endtask

    task automatic t_port_regs();
        apb_write(12'h000, 32'h1234_5678);
        apb_write(12'h004, 32'hFFFF_0000);
        apb_read(12'h000); check("R2", "port A value readback", c_rd, 32'h1234_5678);
        apb_read(12'h004); check("R2", "port A dir readback", c_rd, 32'hFFFF_0000);
        check("R2", "port A gpio_out", gpio_out[31:0], 32'h1234_5678);
        check("R2", "port A gpio_oe", gpio_oe[31:0], 32'hFFFF_0000);
        apb_write(12'h00c, 32'hFFFF_FFFF);
        apb_read(12'h00c); check("R4", "port B 20-line value", c_rd, 32'h000F_FFFF);
        check("R4", "port B gpio_out", gpio_out[63:32], 32'h000F_FFFF);
        check("R2", "port A value untouched by port B write", gpio_out[31:0], 32'h1234_5678);
        apb_write(12'h01c, 32'hFFFF_FFFF);
        apb_read(12'h01c); check("R4", "port C 8-line dir", c_rd, 32'h0000_00FF);
        check("R4", "port C gpio_oe", gpio_oe[95:64], 32'h0000_00FF);
        check("R2", "port C value still zero", gpio_out[95:64], 32'h0);
    endtask

    task automatic t_absent_port();
        logic [95:0] out_before, oe_before;
        out_before = gpio_out; oe_before = gpio_oe;
        apb_write(12'h024, 32'hFFFF_FFFF);
        apb_write(12'h028, 32'hFFFF_FFFF);
        apb_read(12'h024); check("R5", "absent port value", c_rd, 32'h0);
        apb_read(12'h028); check("R5", "absent port dir", c_rd, 32'h0);
        pin_in = '1;
        repeat (3) @(negedge clk);
        apb_read(12'h05c); check("R5", "absent port levels", c_rd, 32'h0);
        check("R5", "outputs unchanged", gpio_out, out_before);
        check("R5", "enables unchanged", gpio_oe, oe_before);
        pin_in = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_pin_levels();
        pin_in[31:0] = 32'hA5A5_5A5A;
        apb_read(12'h050); check("R3", "one edge after change", c_rd, 32'h0);
        repeat (2) @(negedge clk);
        apb_read(12'h050); check("R3", "settled level", c_rd, 32'hA5A5_5A5A);
        pin_in[31:0] = 32'h0F0F_3C3C;
        @(negedge clk);
        apb_read(12'h050); check("R3", "two edges after change", c_rd, 32'h0F0F_3C3C);
        pin_in[63:32] = 32'hFFFF_FFFF;
        pin_in[95:64] = 32'h1234_56C3;
        repeat (3) @(negedge clk);
        apb_read(12'h054); check("R4", "port B levels masked", c_rd, 32'h000F_FFFF);
        apb_read(12'h058); check("R4", "port C levels masked", c_rd, 32'h0000_00C3);
    endtask

    task automatic t_irq_writes();
        apb_write(12'h038, 32'h0000_0055);
        check("R6", "base write strobe", c_wr, 1'b1);
        check("R6", "base code at 0x38 (type=2)", c_sel, 3'd2);
        check("R6", "base write data", c_wdata, 32'h55);
        check("R7", "alt code at 0x38 (polarity=3)", c_sel_alt, 3'd3);
        apb_write(12'h04c, 32'hFFFF_FFFF);
        check("R6", "base EOI write strobe", c_wr, 1'b1);
        check("R6", "base EOI code 6", c_sel, 3'd6);
        check("R7", "alt 0x4c unmapped, no strobe", c_wr_alt, 1'b0);
        apb_write(12'h040, 32'h1);
        check("R9", "base status write dropped", c_wr, 1'b0);
        check("R7", "alt EOI at 0x40 written", {c_wr_alt, c_sel_alt}, {1'b1, 3'd6});
        apb_write(12'h03c, 32'h1);
        check("R9", "alt status write dropped", c_wr_alt, 1'b0);
        check("R6", "base polarity strobe", {c_wr, c_sel}, {1'b1, 3'd3});
    endtask

    task automatic t_irq_reads();
        apb_read(12'h034);
        check("R11", "base mask read", c_rd, 32'hC0DE_0001);
        check("R11", "base read strobe", c_rdstb, 1'b1);
        check("R7", "alt 0x34 reads type", c_rd_alt, 32'hC0DE_0002);
        apb_read(12'h044);
        check("R10", "base 0x44 unmapped", c_rd, 32'h0);
        check("R7", "alt 0x44 reads mask", c_rd_alt, 32'hC0DE_0001);
        apb_read(12'h04c);
        check("R8", "base EOI reads zero", c_rd, 32'h0);
        check("R8", "base EOI no read strobe", c_rdstb, 1'b0);
        check("R7", "alt 0x4c reads zero", c_rd_alt, 32'h0);
        apb_read(12'h040);
        check("R11", "base status read", c_rd, 32'hC0DE_0004);
        check("R8", "alt EOI reads zero", {c_rd_alt, c_rdstb_alt}, {32'h0, 1'b0});
        apb_read(12'h048);
        check("R6", "debounce both layouts", {c_rd, c_rd_alt}, {32'hC0DE_0005, 32'hC0DE_0005});
        apb_read(12'h030);
        check("R6", "enable both layouts", {c_rd, c_rd_alt}, {32'hC0DE_0000, 32'hC0DE_0000});
    endtask

    task automatic t_unmapped();
        apb_read(12'h02c); check("R10", "gap 0x2c reads zero", {c_rd, c_rd_alt}, 64'h0);
        check("R10", "no wait state", c_ready, 1'b1);
        apb_read(12'h060); check("R10", "0x60 reads zero", c_rd, 32'h0);
        apb_read(12'h100); check("R10", "high bit set reads zero", c_rd, 32'h0);
        apb_read(12'h130);
        check("R10", "aliased irq offset no strobe", {c_rdstb, c_rd}, {1'b0, 32'h0});
        apb_write(12'h100, 32'hDEAD_BEEF);
        check("R10", "aliased port write ignored", gpio_out[31:0], 32'h1234_5678);
    endtask

    initial begin
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
        pin_in = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_port_regs();
        t_absent_port();
        t_pin_levels();
        t_irq_writes();
        t_irq_reads();
        t_unmapped();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            applied++;
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule